// File: doc/BRIEF.md
# Flash Command Status and Interrupt Unit

This block is the register front of a flash command engine. A host writes a command code, two configuration words and an interrupt-acknowledge mask over a plain 16-bit register bus, and reads back the command, the configuration, the controller status word with its sticky error flags, and the interrupt status word with its per-operation completion flags. The operation back-end tells the block when a load, program or erase finishes, and whether it failed. The block turns that report into status bits, a polarity-selectable interrupt line and a ready line.

A set master interrupt flag means that the previous operation has not yet been acknowledged. While it is set, new command writes are dropped. An accepted command that the block recognises is handed to the back-end as a one-cycle start pulse together with its code. An unrecognised code is flagged at once as a command error. The two reset codes put the registers into their warm-reset state. Clearing the master flag through the acknowledge write also wipes every error flag.

Top module: `flash_cmd_irq_unit`

## Requirements
- R1: After the synchronous reset `rst`, the register values read back as follows: command 0x0000, configuration-1 0x40C0, configuration-2 0x0000, controller status 0x0000, interrupt status 0x8080. `ready_o` is 1 and `irq_o` is 1. The register offsets are: 0 command, 1 configuration-1, 2 configuration-2, 3 controller status, 4 interrupt status.
- R2: A write to the command offset while interrupt bit 15 is set has no effect. The command register keeps its value and no start pulse is issued.
- R3: When bit 15 is clear, a write of a known non-reset code is latched into the command register. In the next cycle `cmd_start_o` is high for exactly one cycle, and `cmd_code_o` equals the written value. The known codes are 0x00, 0x13, 0x80, 0x1A, 0x1B, 0x23, 0x27, 0x2A, 0x2C, 0x71, 0x94, 0x95, 0xB0, 0x30 and 0x65.
- R4: An accepted write of a code that is neither known nor a reset code is latched and issues no start pulse. It sets controller status bit 10 (command error) and interrupt bit 15.
- R5: An accepted write of 0x00F0 or 0x00F3 applies the warm-reset values. These are the R1 values except that interrupt status becomes 0x8010 (bit 4, reset done). No start pulse is issued.
- R6: A write to the interrupt offset replaces the interrupt status with the bitwise AND of the old value and the written value.
- R7: If interrupt bit 15 is clear after an acknowledge write, controller status bits 13:10 are all cleared. If bit 15 is still set, those bits keep their value.
- R8: A cycle with `done_valid_i` high sets interrupt bit 15 and one done bit, chosen by `done_kind_i`: 0 = load sets bit 7, 1 = program sets bit 6, 2 = erase sets bit 5, and 3 sets no done bit. With `done_err_i` high it also sets status bit 10 and one error bit: load sets bit 13, program sets bit 12, erase sets bit 11. These set operations take priority over an acknowledge write in the same cycle.
- R9: `irq_o` equals interrupt bit 15 when configuration-1 bit 6 is 1, and its inverse when that bit is 0. It follows the registered values, so it changes in the cycle after they update.
- R10: `ready_o` takes the value of bit 7 of every write to configuration-1, and is 1 after any reset.
- R11: A read of configuration-1 returns the stored value with bits 4:0 forced to zero. Configuration-2 reads back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| bus_req_i | input | 1 | Register access valid this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Register offset |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i`, combinational |
| done_valid_i | input | 1 | Back-end operation finished |
| done_kind_i | input | 2 | Finished operation: 0 load, 1 program, 2 erase |
| done_err_i | input | 1 | Finished operation failed |
| cmd_start_o | output | 1 | One-cycle pulse for an accepted known command |
| cmd_code_o | output | 16 | Latched command code |
| irq_o | output | 1 | Interrupt line, polarity from configuration-1 bit 6 |
| ready_o | output | 1 | Ready line |

## Verification
The bench writes a command while the master flag is still pending. A design that fails to gate the write would pulse `cmd_start_o` or change the command readback. It acknowledges with a mask that keeps bit 15, and then with one that drops it. A design that wipes the errors too early loses them on the first mask, and one that never wipes them keeps them after the second. It issues an acknowledge and a completion in the same cycle, where a design with the wrong priority loses the completion. It also sets both polarities, uses a configuration-1 value with its low bits set, and writes a reset code. These catch an inverted `irq_o`, an unmasked readback, and a warm reset that restores the cold interrupt value.

// File: rtl/fcsi_pkg.sv
package fcsi_pkg;

    localparam int FC_DW = 16;

    // controller status error flags
    localparam int ST_ERR_CMD_B   = 10;
    localparam int ST_ERR_ERASE_B = 11;
    localparam int ST_ERR_PROG_B  = 12;
    localparam int ST_ERR_LOAD_B  = 13;

    // interrupt status flags
    localparam int IS_RST_DONE_B   = 4;
    localparam int IS_ERASE_DONE_B = 5;
    localparam int IS_PROG_DONE_B  = 6;
    localparam int IS_LOAD_DONE_B  = 7;
    localparam int IS_MASTER_B     = 15;

    // configuration-1 control bits
    localparam int CF_POL_B = 6;
    localparam int CF_RDY_B = 7;

    localparam logic [FC_DW-1:0] CFG1_INIT    = 16'h40C0;
    localparam logic [FC_DW-1:0] INT_COLD     = 16'h8080;
    localparam logic [FC_DW-1:0] INT_WARM     = 16'h8010;
    localparam logic [FC_DW-1:0] CFG1_RD_MASK = 16'hFFE0;
    localparam logic [FC_DW-1:0] ERR_MASK     = 16'h3C00;

    // register offsets
    localparam int RO_CMD  = 0;
    localparam int RO_CFG1 = 1;
    localparam int RO_CFG2 = 2;
    localparam int RO_STAT = 3;
    localparam int RO_INT  = 4;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_RSVD  = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        CK_RUN     = 2'd0,
        CK_UNKNOWN = 2'd1,
        CK_RESET   = 2'd2
    } cmd_class_e;

    typedef struct packed {
        logic cmd;
        logic cfg1;
        logic cfg2;
        logic intr;
    } wr_strobe_t;

    typedef struct packed {
        logic       valid;
        op_kind_e   kind;
        logic       err;
    } done_evt_t;

    function automatic cmd_class_e classify_cmd(input logic [FC_DW-1:0] code);
        cmd_class_e c;
        case (code)
            16'h00F0, 16'h00F3: c = CK_RESET;
            16'h0000, 16'h0013, 16'h0080, 16'h001A, 16'h001B,
            16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0071,
            16'h0094, 16'h0095, 16'h00B0, 16'h0030, 16'h0065: c = CK_RUN;
            default: c = CK_UNKNOWN;
        endcase
        return c;
    endfunction

    function automatic logic [FC_DW-1:0] done_set_bits(input op_kind_e k);
        logic [FC_DW-1:0] m;
        m = '0;
        m[IS_MASTER_B] = 1'b1;
        case (k)
            OP_LOAD:  m[IS_LOAD_DONE_B]  = 1'b1;
            OP_PROG:  m[IS_PROG_DONE_B]  = 1'b1;
            OP_ERASE: m[IS_ERASE_DONE_B] = 1'b1;
            default:  ;
        endcase
        return m;
    endfunction

    function automatic logic [FC_DW-1:0] err_set_bits(input op_kind_e k);
        logic [FC_DW-1:0] m;
        m = '0;
        m[ST_ERR_CMD_B] = 1'b1;
        case (k)
            OP_LOAD:  m[ST_ERR_LOAD_B]  = 1'b1;
            OP_PROG:  m[ST_ERR_PROG_B]  = 1'b1;
            OP_ERASE: m[ST_ERR_ERASE_B] = 1'b1;
            default:  ;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/fcsi_bus_dec.sv
module fcsi_bus_dec
    import fcsi_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    output wr_strobe_t        wr_o
);
    logic wr_any;
    assign wr_any = req_i && we_i;

    always_comb begin
        wr_o      = '0;
        wr_o.cmd  = wr_any && (addr_i == ADDR_W'(RO_CMD));
        wr_o.cfg1 = wr_any && (addr_i == ADDR_W'(RO_CFG1));
        wr_o.cfg2 = wr_any && (addr_i == ADDR_W'(RO_CFG2));
        wr_o.intr = wr_any && (addr_i == ADDR_W'(RO_INT));
    end
endmodule

// File: rtl/fcsi_cmd_gate.sv
module fcsi_cmd_gate
    import fcsi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr_i,
    input  logic [FC_DW-1:0] wdata_i,
    input  logic             master_i,
    output logic [FC_DW-1:0] cmd_q_o,
    output logic             start_o,
    output logic             unknown_o,
    output logic             warm_o
);
    logic       accept;
    cmd_class_e cls;
    logic       start_q;

    assign accept    = cmd_wr_i && !master_i;
    assign cls       = classify_cmd(wdata_i);
    assign unknown_o = accept && (cls == CK_UNKNOWN);
    assign warm_o    = accept && (cls == CK_RESET);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q_o <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= accept && (cls == CK_RUN);
            if (warm_o) begin
                cmd_q_o <= '0;
            end else if (accept) begin
                cmd_q_o <= wdata_i;
            end
        end
    end

    assign start_o = start_q;
endmodule

// File: rtl/fcsi_stat_regs.sv
module fcsi_stat_regs
    import fcsi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wr_strobe_t       wr_i,
    input  logic [FC_DW-1:0] wdata_i,
    input  logic             unknown_i,
    input  logic             warm_i,
    input  done_evt_t        done_i,
    output logic [FC_DW-1:0] cfg1_q_o,
    output logic [FC_DW-1:0] cfg2_q_o,
    output logic [FC_DW-1:0] stat_q_o,
    output logic [FC_DW-1:0] int_q_o,
    output logic             ready_q_o
);
    logic [FC_DW-1:0] int_n;
    logic [FC_DW-1:0] stat_n;

    // acknowledge first, then event sets so a completion is never lost
    always_comb begin
        int_n  = int_q_o;
        stat_n = stat_q_o;
        if (wr_i.intr) begin
            int_n = int_q_o & wdata_i;
            if (!int_n[IS_MASTER_B]) begin
                stat_n = stat_q_o & ~ERR_MASK;
            end
        end
        if (unknown_i) begin
            int_n[IS_MASTER_B]   = 1'b1;
            stat_n[ST_ERR_CMD_B] = 1'b1;
        end
        if (done_i.valid) begin
            int_n = int_n | done_set_bits(done_i.kind);
            if (done_i.err) begin
                stat_n = stat_n | err_set_bits(done_i.kind);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg1_q_o  <= CFG1_INIT;
            cfg2_q_o  <= '0;
            stat_q_o  <= '0;
            int_q_o   <= INT_COLD;
            ready_q_o <= 1'b1;
        end else if (warm_i) begin
            cfg1_q_o  <= CFG1_INIT;
            cfg2_q_o  <= '0;
            stat_q_o  <= '0;
            int_q_o   <= INT_WARM;
            ready_q_o <= 1'b1;
        end else begin
            if (wr_i.cfg1) begin
                cfg1_q_o  <= wdata_i;
                ready_q_o <= wdata_i[CF_RDY_B];
            end
            if (wr_i.cfg2) begin
                cfg2_q_o <= wdata_i;
            end
            int_q_o  <= int_n;
            stat_q_o <= stat_n;
        end
    end
endmodule

// File: rtl/flash_cmd_irq_unit.sv
module flash_cmd_irq_unit
    import fcsi_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [15:0]       bus_wdata_i,
    output logic [15:0]       bus_rdata_o,
    input  logic              done_valid_i,
    input  logic [1:0]        done_kind_i,
    input  logic              done_err_i,
    output logic              cmd_start_o,
    output logic [15:0]       cmd_code_o,
    output logic              irq_o,
    output logic              ready_o
);
    wr_strobe_t       wr;
    done_evt_t        done_evt;
    logic [FC_DW-1:0] cmd_q;
    logic [FC_DW-1:0] cfg1_q;
    logic [FC_DW-1:0] cfg2_q;
    logic [FC_DW-1:0] stat_q;
    logic [FC_DW-1:0] int_q;
    logic             unknown_cmd;
    logic             warm_rst;

    assign done_evt.valid = done_valid_i;
    assign done_evt.kind  = op_kind_e'(done_kind_i);
    assign done_evt.err   = done_err_i;

    fcsi_bus_dec #(.ADDR_W(ADDR_W)) dec_i (
        .req_i  (bus_req_i),
        .we_i   (bus_we_i),
        .addr_i (bus_addr_i),
        .wr_o   (wr)
    );

    fcsi_cmd_gate gate_i (
        .clk       (clk),
        .rst       (rst),
        .cmd_wr_i  (wr.cmd),
        .wdata_i   (bus_wdata_i),
        .master_i  (int_q[IS_MASTER_B]),
        .cmd_q_o   (cmd_q),
        .start_o   (cmd_start_o),
        .unknown_o (unknown_cmd),
        .warm_o    (warm_rst)
    );

    fcsi_stat_regs regs_i (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (wr),
        .wdata_i   (bus_wdata_i),
        .unknown_i (unknown_cmd),
        .warm_i    (warm_rst),
        .done_i    (done_evt),
        .cfg1_q_o  (cfg1_q),
        .cfg2_q_o  (cfg2_q),
        .stat_q_o  (stat_q),
        .int_q_o   (int_q),
        .ready_q_o (ready_o)
    );

    always_comb begin
        case (int'(bus_addr_i))
            RO_CMD:  bus_rdata_o = cmd_q;
            RO_CFG1: bus_rdata_o = cfg1_q & CFG1_RD_MASK;
            RO_CFG2: bus_rdata_o = cfg2_q;
            RO_STAT: bus_rdata_o = stat_q;
            RO_INT:  bus_rdata_o = int_q;
            default: bus_rdata_o = '0;
        endcase
    end

    assign cmd_code_o = cmd_q;
    assign irq_o      = int_q[IS_MASTER_B] ^ ~cfg1_q[CF_POL_B];
endmodule

// File: rtl/fcsi_checker.sv
module fcsi_checker
    import fcsi_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_req_i,
    input logic              bus_we_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              wdata_rdy,
    input logic              done_valid_i,
    input logic              cmd_start_o,
    input logic [15:0]       cmd_code_o,
    input logic              irq_o,
    input logic              ready_o,
    input logic              master,
    input logic              pol,
    input logic [3:0]        err_bits
);
    logic cmd_wr;
    logic cfg1_wr;
    assign cmd_wr  = bus_req_i && bus_we_i && (bus_addr_i == ADDR_W'(RO_CMD));
    assign cfg1_wr = bus_req_i && bus_we_i && (bus_addr_i == ADDR_W'(RO_CFG1));

    a_r2_cmd_blocked: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && master) |=> (!cmd_start_o && $stable(cmd_code_o)));

    a_r3_start_from_write: assert property (@(posedge clk) disable iff (rst)
        cmd_start_o |-> $past(cmd_wr));

    a_r7_no_err_without_master: assert property (@(posedge clk) disable iff (rst)
        !master |-> (err_bits == 4'b0000));

    a_r8_done_sets_master: assert property (@(posedge clk) disable iff (rst)
        done_valid_i |=> master);

    a_r9_irq_active_high: assert property (@(posedge clk) disable iff (rst)
        pol |-> (irq_o == master));

    a_r9_irq_active_low: assert property (@(posedge clk) disable iff (rst)
        !pol |-> (irq_o == !master));

    a_r10_ready_follows: assert property (@(posedge clk) disable iff (rst)
        cfg1_wr |=> (ready_o == $past(wdata_rdy)));
endmodule

bind flash_cmd_irq_unit fcsi_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .bus_req_i    (bus_req_i),
    .bus_we_i     (bus_we_i),
    .bus_addr_i   (bus_addr_i),
    .wdata_rdy    (bus_wdata_i[7]),
    .done_valid_i (done_valid_i),
    .cmd_start_o  (cmd_start_o),
    .cmd_code_o   (cmd_code_o),
    .irq_o        (irq_o),
    .ready_o      (ready_o),
    .master       (int_q[15]),
    .pol          (cfg1_q[6]),
    .err_bits     (stat_q[13:10])
);

// File: tb/flash_cmd_irq_unit_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_irq_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        dv = 1'b0;
    logic [1:0]  dk = '0;
    logic        de = 1'b0;
    logic        start;
    logic [15:0] code;
    logic        irq;
    logic        rdy;

    int nvec = 0;
    int nbad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    flash_cmd_irq_unit #(.ADDR_W(3)) dut_i (
        .clk(clk), .rst(rst), .bus_req_i(req), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .done_valid_i(dv), .done_kind_i(dk), .done_err_i(de),
        .cmd_start_o(start), .cmd_code_o(code), .irq_o(irq), .ready_o(rdy)
    );

    task automatic chk(input string req_tag, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic complete(input logic [1:0] k, input logic e);
        @(negedge clk);
        dv = 1'b1; dk = k; de = e;
        @(negedge clk);
        dv = 1'b0; de = 1'b0;
    endtask

    task automatic t_reset_values();
        logic [15:0] d;
        bus_rd(3'd0, d); chk("R1 cmd", d, 16'h0000);
        bus_rd(3'd1, d); chk("R1 cfg1", d, 16'h40C0);
        bus_rd(3'd2, d); chk("R1 cfg2", d, 16'h0000);
        bus_rd(3'd3, d); chk("R1 stat", d, 16'h0000);
        bus_rd(3'd4, d); chk("R1 int", d, 16'h8080);
        chk("R1 ready", {15'd0, rdy}, 16'd1);
        chk("R1 irq", {15'd0, irq}, 16'd1);
    endtask

    task automatic t_blocked_cmd();
        logic [15:0] d;
        bus_wr(3'd0, 16'h0094);
        chk("R2 no start", {15'd0, start}, 16'd0);
        bus_rd(3'd0, d); chk("R2 cmd kept", d, 16'h0000);
    endtask

    task automatic t_ack_and_irq();
        logic [15:0] d;
        bus_wr(3'd4, 16'h0000);
        bus_rd(3'd4, d); chk("R6 int and", d, 16'h0000);
        chk("R9 irq low active-high", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_known_cmd(input logic [15:0] c);
        logic [15:0] d;
        bus_wr(3'd0, c);
        chk("R3 start high", {15'd0, start}, 16'd1);
        chk("R3 code", code, c);
        @(negedge clk);
        chk("R3 start one cycle", {15'd0, start}, 16'd0);
        bus_rd(3'd0, d); chk("R3 cmd readback", d, c);
    endtask

    task automatic t_completion();
        logic [15:0] d;
        complete(2'd2, 1'b1);
        bus_rd(3'd4, d); chk("R8 erase int", d, 16'h8020);
        bus_rd(3'd3, d); chk("R8 erase err", d, 16'h0C00);
        chk("R9 irq high", {15'd0, irq}, 16'd1);
        bus_wr(3'd4, 16'hFFFF);
        bus_rd(3'd4, d); chk("R6 and keep", d, 16'h8020);
        bus_rd(3'd3, d); chk("R7 err kept", d, 16'h0C00);
        bus_wr(3'd4, 16'h7FFF);
        bus_rd(3'd4, d); chk("R6 and drop master", d, 16'h0020);
        bus_rd(3'd3, d); chk("R7 err wiped", d, 16'h0000);
        bus_wr(3'd4, 16'h0000);
        complete(2'd0, 1'b0);
        bus_rd(3'd4, d); chk("R8 load int", d, 16'h8080);
        bus_rd(3'd3, d); chk("R8 load no err", d, 16'h0000);
        bus_wr(3'd4, 16'h0000);
        complete(2'd1, 1'b1);
        bus_rd(3'd4, d); chk("R8 prog int", d, 16'h8040);
        bus_rd(3'd3, d); chk("R8 prog err", d, 16'h1400);
    endtask

    task automatic t_unknown_cmd();
        logic [15:0] d;
        bus_wr(3'd4, 16'h0000);
        bus_wr(3'd0, 16'h0055);
        chk("R4 no start", {15'd0, start}, 16'd0);
        bus_rd(3'd3, d); chk("R4 cmd err", d, 16'h0400);
        bus_rd(3'd4, d); chk("R4 master", d, 16'h8000);
        bus_rd(3'd0, d); chk("R4 latched", d, 16'h0055);
    endtask

    task automatic t_config();
        logic [15:0] d;
        bus_wr(3'd1, 16'h0080);
        chk("R9 irq active-low", {15'd0, irq}, 16'd0);
        chk("R10 ready set", {15'd0, rdy}, 16'd1);
        bus_rd(3'd1, d); chk("R11 cfg1 read", d, 16'h0080);
        bus_wr(3'd1, 16'h005F);
        chk("R10 ready clear", {15'd0, rdy}, 16'd0);
        chk("R9 irq back high", {15'd0, irq}, 16'd1);
        bus_rd(3'd1, d); chk("R11 cfg1 masked", d, 16'h0040);
        bus_wr(3'd2, 16'hA5C3);
        bus_rd(3'd2, d); chk("R11 cfg2 read", d, 16'hA5C3);
    endtask

    task automatic t_warm_reset();
        logic [15:0] d;
        bus_wr(3'd4, 16'h0000);
        bus_wr(3'd0, 16'h00F3);
        chk("R5 no start", {15'd0, start}, 16'd0);
        bus_rd(3'd4, d); chk("R5 int warm", d, 16'h8010);
        bus_rd(3'd1, d); chk("R5 cfg1", d, 16'h40C0);
        bus_rd(3'd2, d); chk("R5 cfg2", d, 16'h0000);
        bus_rd(3'd0, d); chk("R5 cmd", d, 16'h0000);
        bus_rd(3'd3, d); chk("R5 stat", d, 16'h0000);
        chk("R5 ready", {15'd0, rdy}, 16'd1);
    endtask

    task automatic t_collision();
        logic [15:0] d;
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 3'd4; wdata = 16'h0000;
        dv = 1'b1; dk = 2'd1; de = 1'b1;
        @(negedge clk);
        req = 1'b0; we = 1'b0; dv = 1'b0; de = 1'b0;
        bus_rd(3'd4, d); chk("R8 collision int", d, 16'h8040);
        bus_rd(3'd3, d); chk("R8 collision err", d, 16'h1400);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_values();
        t_blocked_cmd();
        t_ack_and_irq();
        t_known_cmd(16'h0094);
        t_known_cmd(16'h0065);
        t_completion();
        t_unknown_cmd();
        t_config();
        t_warm_reset();
        t_collision();
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nvec++;
            nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule